// File: doc/BRIEF.md
# Prioritized Transfer Descriptor Scheduler

In each microframe this block walks three tables of transfer descriptor slots in a fixed order. The isochronous table comes first, then the interrupt table, then the asynchronous table that serves control and bulk traffic. For every class it takes a schedule enable bit, a bitmap that marks which slots hold a valid descriptor, and an end-marker index. Slots above the end marker count as empty even if their valid bit is set. The scheduler picks the lowest valid slot at or above its scan pointer. It reports that slot to an execution engine with a one-cycle issue strobe and waits for a done pulse before it looks for the next slot.

A microframe start strobe arrives every 125 µs. It sends the scan back to isochronous slot 0, even when the previous scan has not finished. A class that is disabled, or that has no pending slot left, is passed over at a cost of one cycle. After the asynchronous class is exhausted the idle flag rises. It stays high, and nothing is issued, until the next start strobe.

Top module: `ptd_sched`

## Requirements
- R1: Out of reset, issue is 0 and idle is 1. No issue strobe occurs before the first microframe start strobe, whatever the slot maps hold.
- R2: A class whose enable bit is 0 (bit 0 isochronous, bit 1 interrupt, bit 2 asynchronous) never has a slot issued.
- R3: An issued slot has its valid bit set, and its index is not above the end marker of its class. Slots above the marker are never issued.
- R4: Within one microframe, every issue of class code 0 (isochronous) comes before every issue of code 1 (interrupt), and every issue of code 1 comes before every issue of code 2 (asynchronous).
- R5: Within a class, slots are issued in strictly ascending index order. Each valid slot inside the marker is issued exactly once per microframe.
- R6: At most one descriptor is outstanding. After an issue strobe, no further strobe occurs until the cycle after the engine's done pulse.
- R7: A start strobe clears idle and restarts the scan at isochronous slot 0, even in the middle of a scan. No issue strobe occurs in the cycle that follows the start strobe.
- R8: Once every class has been scanned, idle stays at 1 and no issue occurs until the next start strobe, even when the maps and markers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_start | input | 1 | Microframe start strobe |
| class_en | input | 3 | Schedule enables: bit 0 isochronous, bit 1 interrupt, bit 2 asynchronous |
| iso_map | input | SLOTS | Valid-slot bitmap, isochronous |
| intr_map | input | SLOTS | Valid-slot bitmap, interrupt |
| async_map | input | SLOTS | Valid-slot bitmap, asynchronous |
| iso_end | input | IDXW | End-marker index, isochronous |
| intr_end | input | IDXW | End-marker index, interrupt |
| async_end | input | IDXW | End-marker index, asynchronous |
| xact_done | input | 1 | Done pulse from the execution engine |
| issue | output | 1 | One-cycle strobe announcing a selected descriptor |
| issue_class | output | 2 | Class of the issued slot (0 iso, 1 interrupt, 2 async) |
| issue_slot | output | IDXW | Index of the issued slot |
| idle | output | 1 | All classes scanned for this microframe |

## Verification
The assertions check the following on every cycle:
- No strobe is issued while a descriptor is outstanding.
- No issue comes from a disabled class.
- No issued slot lies beyond its class marker.
- The class pointer never moves backward between start strobes.
- Idle holds with no issues until a strobe arrives.

Only the bench's scenarios can show the rest:
- The exact issue sequence: that every valid slot is issued once, lowest index first.
- That a start strobe in mid-scan yields a complete fresh sequence.

The bench compares each sequence with a list it computes from the maps, enables and markers.

// File: rtl/ptd_sched.sv
module ptd_sched #(
  parameter int SLOTS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     uframe_start,
  input  logic [2:0]               class_en,
  input  logic [SLOTS-1:0]         iso_map,
  input  logic [SLOTS-1:0]         intr_map,
  input  logic [SLOTS-1:0]         async_map,
  input  logic [$clog2(SLOTS)-1:0] iso_end,
  input  logic [$clog2(SLOTS)-1:0] intr_end,
  input  logic [$clog2(SLOTS)-1:0] async_end,
  input  logic                     xact_done,
  output logic                     issue,
  output logic [1:0]               issue_class,
  output logic [$clog2(SLOTS)-1:0] issue_slot,
  output logic                     idle
);
  localparam int IDXW = $clog2(SLOTS);
  localparam int PW   = IDXW + 1;

  logic [1:0]       cls;
  logic [PW-1:0]    ptr;
  logic             scanning, busy;
  logic [SLOTS-1:0] cur_map, pend;
  logic [IDXW-1:0]  cur_end, pick;
  logic             hit, decide;

  always_comb begin
    case (cls)
      2'd0:    begin cur_map = iso_map;   cur_end = iso_end;   end
      2'd1:    begin cur_map = intr_map;  cur_end = intr_end;  end
      2'd2:    begin cur_map = async_map; cur_end = async_end; end
      default: begin cur_map = '0;        cur_end = '0;        end
    endcase
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < SLOTS; i++)
      pend[i] = cur_map[i] && class_en[cls] &&
                (PW'(i) >= ptr) && (IDXW'(i) <= cur_end);
    for (int i = SLOTS - 1; i >= 0; i--)
      if (pend[i]) pick = IDXW'(i);
  end

  assign hit    = |pend;
  assign decide = scanning && !busy && !uframe_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls         <= 2'd0;
      ptr         <= '0;
      scanning    <= 1'b0;
      busy        <= 1'b0;
      issue       <= 1'b0;
      issue_class <= 2'd0;
      issue_slot  <= '0;
      idle        <= 1'b1;
    end else begin
      issue <= 1'b0;
      if (xact_done) busy <= 1'b0;
      if (uframe_start) begin
        cls      <= 2'd0;
        ptr      <= '0;
        scanning <= 1'b1;
        idle     <= 1'b0;
      end else if (decide) begin
        if (hit) begin
          issue       <= 1'b1;
          issue_class <= cls;
          issue_slot  <= pick;
          ptr         <= PW'(pick) + PW'(1);
          busy        <= 1'b1;
        end else if (cls == 2'd2) begin
          scanning <= 1'b0;
          idle     <= 1'b1;
        end else begin
          cls <= cls + 2'd1;
          ptr <= '0;
        end
      end
    end
  end

  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xact_done) |=> !issue);
  p_no_early_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);
  p_en_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && issue_class == 2'd0) |-> $past(class_en[0]));
  p_en_intr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && issue_class == 2'd1) |-> $past(class_en[1]));
  p_en_async_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && issue_class == 2'd2) |-> $past(class_en[2]));
  p_within_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> issue_slot <= (issue_class == 2'd0 ? $past(iso_end) :
                             issue_class == 2'd1 ? $past(intr_end) : $past(async_end)));
  p_class_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !uframe_start |=> cls >= $past(cls));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_start |=> (!issue && !idle && cls == 2'd0));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !uframe_start) |=> idle);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !issue);
endmodule

// File: tb/ptd_sched_bench.sv
module ptd_sched_bench;
  localparam int SLOTS = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0, sof = 0, done = 0;
  logic [2:0] en = 0;
  logic [SLOTS-1:0] mp [3];
  logic [IW-1:0] ed [3];
  logic issue, idle;
  logic [1:0] icls;
  logic [IW-1:0] islot;

  int checks = 0, errors = 0, cyc = 0;
  int got_n, exp_n;
  int got_c [64], got_s [64], exp_c [64], exp_s [64];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  ptd_sched #(.SLOTS(SLOTS)) u_ptd_sched (
    .clk(clk), .rst_n(rst_n), .uframe_start(sof), .class_en(en),
    .iso_map(mp[0]), .intr_map(mp[1]), .async_map(mp[2]),
    .iso_end(ed[0]), .intr_end(ed[1]), .async_end(ed[2]),
    .xact_done(done), .issue(issue), .issue_class(icls),
    .issue_slot(islot), .idle(idle));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic build_exp();
    exp_n = 0;
    for (int c = 0; c < 3; c++)
      if (en[c])
        for (int s = 0; s < SLOTS; s++)
          if (s <= int'(ed[c]) && mp[c][s]) begin
            exp_c[exp_n] = c; exp_s[exp_n] = s; exp_n++;
          end
  endtask

  task automatic start_frame();
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
    chk(!issue && !idle, "R7 strobe clears idle, no issue", {issue, idle}, 0);
  endtask

  task automatic collect(input int maxn, input int dly);
    got_n = 0;
    for (int t = 0; t < 800; t++) begin
      @(negedge clk);
      if (issue) begin
        got_c[got_n] = icls; got_s[got_n] = islot; got_n++;
        for (int d = 0; d < dly; d++) begin
          @(negedge clk);
          chk(!issue, "R6 issue while outstanding", issue, 0);
        end
        done = 1;
        @(negedge clk);
        done = 0;
        chk(!issue, "R6 issue in done cycle", issue, 0);
        if (got_n == maxn) return;
      end else if (idle) return;
    end
  endtask

  task automatic compare(input string tag);
    int bad;
    chk(got_n == exp_n, {"R5 issue count ", tag}, got_n, exp_n);
    bad = 0;
    for (int i = 0; i < got_n; i++) if (!en[got_c[i]]) bad++;
    chk(bad == 0, {"R2 disabled class issued ", tag}, bad, 0);
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      chk(got_c[i] == exp_c[i], {"R4 class order ", tag}, got_c[i], exp_c[i]);
      chk(got_s[i] == exp_s[i], {"R3 slot choice ", tag}, got_s[i], exp_s[i]);
    end
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) begin mp[c] = '1; ed[c] = '1; end
    en = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!issue && idle, "R1 reset state", {issue, idle}, 1);
    repeat (6) begin
      @(negedge clk);
      chk(!issue && idle, "R1 no issue before strobe", {issue, idle}, 1);
    end

    for (int e = 0; e < 8; e++)
      for (int p = 0; p < 14; p++) begin
        en = 3'(e);
        for (int c = 0; c < 3; c++) begin
          step_lfsr();
          mp[c] = (p == 0) ? '1 : lfsr[SLOTS-1:0];
          ed[c] = (p == 0) ? '1 : (p == 1) ? '0 : lfsr[IW+15:16];
        end
        build_exp();
        start_frame();
        collect(64, p % 3);
        compare("sweep");
        chk(idle == 1, "R8 idle after scan", idle, 1);
        for (int k = 0; k < 4; k++) begin
          step_lfsr();
          mp[k % 3] = lfsr[SLOTS-1:0];
          ed[k % 3] = lfsr[IW+3:4];
          @(negedge clk);
          chk(!issue && idle, "R8 idle holds, inputs ignored", {issue, idle}, 1);
        end
      end

    for (int r = 0; r < 6; r++) begin
      en = 3'b111;
      for (int c = 0; c < 3; c++) begin
        step_lfsr();
        mp[c] = lfsr[SLOTS-1:0] | 8'h11;
        ed[c] = '1;
      end
      build_exp();
      start_frame();
      collect(1 + r % 3, r % 2);
      sof = 1;
      @(negedge clk); sof = 0;
      chk(!issue && !idle, "R7 mid-scan strobe", {issue, idle}, 0);
      collect(64, 1);
      compare("R7 restart");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule